// File: doc/BRIEF.md
# Keyed Record Query Responder

This block is a byte-wide slave on a simple host I/O bus. It has two ports inside a 32-address window: a data port and a command/status port. The host opens a query by writing the read command to the command port, then writes a four-character key and a requested length to the data port. The block matches the key against a small constant table of records and copies the matching record into a 32-byte buffer. The host then reads the record back one byte per data-port read.

A status byte, readable at the command port, shows which phase the query is in: armed, key entry, length accepted with data pending, or done. The other command codes (write, get-key-by-index, get-key-type) are only latched. While one of them is latched, the data port does nothing. Two of the table records carry a 64-byte secret supplied as a parameter, split into two 32-byte halves.

Top module: `kvq_responder`

## Requirements
- R1: Address decode uses a base (default 0x300) and a 32-address window. Offsets 0 to 3 select the data port and offsets 4 to 7 select the command/status port. Reads of any other address return 0x00, and writes to any other address have no effect.
- R2: A command-port write latches the byte as the command and clears both the key-entry and the readout positions. If the byte is 0x10 (read), the status becomes 0x0C. Any other code leaves the status unchanged.
- R3: Under the read command, data writes 1 to 4 are stored as key characters in order, the first being the leftmost ASCII character. Each of these writes sets the status to 0x04.
- R4: Under the read command, data write 5 is the requested length. It sets the status to 0x05, resets the readout position and starts the lookup. A length above 32 is treated as 32. Data writes after the fifth change nothing.
- R5: The table holds six records. "REV " is 6 bytes: 01 13 0F 00 00 03. "OSK0" is secret bytes 0 to 31. "OSK1" is secret bytes 32 to 63. "NATJ", "MSSP" and "MSSD" are one byte each, 0x00. Secret byte i sits at bits [8i+7:8i] of the parameter.
- R6: On a match, the buffer loads only the first N bytes, where N is the record's own length, and keeps its other bytes. On a miss, the whole buffer keeps its earlier contents.
- R7: Under the read command, while the readout position is below the length, a data read returns the buffered byte at that position and advances the position. The status becomes 0x00 after the last byte and 0x05 after any earlier byte.
- R8: A data read past the end, or under any command other than read, returns 0x00 and changes neither the position nor the status. A data write under any other command has no effect.
- R9: A status read returns the status and has no side effect. When a command write and a status read hit in the same cycle, the read returns the status from before the write.
- R10: A synchronous active-low reset sets the command and status to 0x00, both positions to 0 and every buffer byte to 0x00.
- R11: A data-port cycle with both read and write strobes applies the write. The read half returns 0x00 and does not advance the readout position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Host I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |

## Verification
The command-port write and the status read can land in the same cycle. The bench raises both strobes on the command address while the status is known. It judges that the returned byte is the old status and that a later read shows the new one. A data-port cycle with both strobes pits the write path against readout advance. The bench drives one right after the length write and then reads the stream to confirm that its first byte was not consumed.

// File: rtl/kvq_pkg.sv
// Package: shared codes for the keyed record query responder.
// Assumes byte-wide host accesses; secret byte i lives at bits [8i+7:8i].
package kvq_pkg;
    localparam logic [7:0] CMD_READ     = 8'h10;
    localparam logic [7:0] CMD_WRITE    = 8'h11;
    localparam logic [7:0] CMD_BY_INDEX = 8'h12;
    localparam logic [7:0] CMD_KEY_TYPE = 8'h13;

    localparam logic [7:0] ST_IDLE  = 8'h00;
    localparam logic [7:0] ST_KEY   = 8'h04;
    localparam logic [7:0] ST_DATA  = 8'h05;
    localparam logic [7:0] ST_ARMED = 8'h0C;

    localparam int SECRET_BYTES = 64;
    localparam int REC_BYTES    = 32;

    // Placeholder secret: byte i = (3*i + 7) mod 256
    function automatic logic [SECRET_BYTES*8-1:0] demo_secret();
        logic [SECRET_BYTES*8-1:0] s;
        s = '0;
        for (int i = 0; i < SECRET_BYTES; i++) begin
            s[8*i +: 8] = 8'((3 * i + 7) % 256);
        end
        return s;
    endfunction
endpackage

// File: rtl/kvq_decode.sv
// Module: address decode for the two host ports.
// Assumes the window starts at BASE and spans WINDOW addresses; offsets 0-3
// are the data port, 4-7 the command/status port, the rest are unused.
module kvq_decode #(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE   = 16'h0300,
    parameter int          WINDOW = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              data_wr,
    output logic              data_rd,
    output logic              cmd_wr,
    output logic              cmd_rd
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] WIN_A  = ADDR_W'(WINDOW);

    logic [ADDR_W-1:0] off;
    logic              in_win, sel_data, sel_cmd;

    // Offset and port selection
    always_comb begin
        off      = addr - BASE_A;
        in_win   = (addr >= BASE_A) && (off < WIN_A);
        sel_data = in_win && (off < ADDR_W'(4));
        sel_cmd  = in_win && (off >= ADDR_W'(4)) && (off < ADDR_W'(8));
    end

    // Strobe qualification; a data read that shares its cycle with a write is dropped
    always_comb begin
        data_wr = sel_data && wr;
        data_rd = sel_data && rd && !wr;
        cmd_wr  = sel_cmd && wr;
        cmd_rd  = sel_cmd && rd;
    end
endmodule

// File: rtl/kvq_table.sv
// Module: constant record table with combinational key match.
// Assumes keys are unique; the lowest entry index wins if two ever match.
module kvq_table #(
    parameter int                                BUF_BYTES = 32,
    parameter logic [kvq_pkg::SECRET_BYTES*8-1:0] SECRET   = kvq_pkg::demo_secret()
) (
    input  logic [31:0]            key,
    output logic                   hit,
    output logic [7:0]             rec_len,
    output logic [BUF_BYTES*8-1:0] rec_data
);
    import kvq_pkg::*;
    localparam int NUM = 6;
    localparam int RB  = REC_BYTES;

    function automatic logic [31:0] entry_key(int e);
        case (e)
            0:       return "REV ";
            1:       return "OSK0";
            2:       return "OSK1";
            3:       return "NATJ";
            4:       return "MSSP";
            default: return "MSSD";
        endcase
    endfunction

    function automatic logic [7:0] entry_len(int e);
        case (e)
            0:       return 8'd6;
            1, 2:    return 8'd32;
            default: return 8'd1;
        endcase
    endfunction

    function automatic logic [RB*8-1:0] entry_data(int e);
        logic [RB*8-1:0] d;
        d = '0;
        case (e)
            0:       d[47:0] = 48'h03_00_00_0F_13_01;
            1:       d = SECRET[RB*8-1:0];
            2:       d = SECRET[2*RB*8-1:RB*8];
            default: d = '0;
        endcase
        return d;
    endfunction

    logic [NUM-1:0]  match;
    logic [RB*8-1:0] sel_rec;

    for (genvar e = 0; e < NUM; e++) begin : g_cmp
        assign match[e] = (key == entry_key(e));
    end

    // Priority select of the matching record
    always_comb begin
        hit     = 1'b0;
        rec_len = 8'd0;
        sel_rec = '0;
        for (int e = NUM - 1; e >= 0; e--) begin
            if (match[e]) begin
                hit     = 1'b1;
                rec_len = entry_len(e);
                sel_rec = entry_data(e);
            end
        end
    end

    for (genvar b = 0; b < BUF_BYTES; b++) begin : g_out
        if (b < RB) begin : g_real
            assign rec_data[8*b +: 8] = sel_rec[8*b +: 8];
        end else begin : g_pad
            assign rec_data[8*b +: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/kvq_buffer.sv
// Module: record buffer with per-byte load enable and indexed readout.
// Assumes rd_idx < BUF_BYTES whenever its byte is used.
module kvq_buffer #(
    parameter int BUF_BYTES = 32,
    localparam int IW = $clog2(BUF_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [7:0]             src_len,
    input  logic [BUF_BYTES*8-1:0] src_data,
    input  logic [IW-1:0]          rd_idx,
    output logic [7:0]             rd_byte
);
    logic [BUF_BYTES*8-1:0] mem;

    // Load only the bytes covered by the record length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (load) begin
            for (int i = 0; i < BUF_BYTES; i++) begin
                if (8'(i) < src_len) begin
                    mem[8*i +: 8] <= src_data[8*i +: 8];
                end
            end
        end
    end

    // Readout mux
    assign rd_byte = mem[8*rd_idx +: 8];
endmodule

// File: rtl/kvq_ctrl.sv
// Module: command latch, phase/status sequencing and position counters.
// Assumes the decoder never raises a data strobe and a command strobe together.
module kvq_ctrl #(
    parameter int BUF_BYTES = 32,
    localparam int PW = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic [7:0]    wdata,
    output logic [7:0]    cmd_q,
    output logic [7:0]    status_q,
    output logic [31:0]   key_q,
    output logic [PW-1:0] rpos_q,
    output logic [PW-1:0] len_q,
    output logic          lookup,
    output logic          rd_valid
);
    import kvq_pkg::*;

    logic [2:0]    wpos_q;
    logic          is_read;
    logic [PW-1:0] len_cap;
    logic [PW-1:0] rpos_nx;

    // Decode of the current phase
    always_comb begin
        is_read  = (cmd_q == CMD_READ);
        lookup   = data_wr && is_read && (wpos_q == 3'd4);
        rd_valid = is_read && (rpos_q < len_q);
        len_cap  = (int'(wdata) > BUF_BYTES) ? PW'(BUF_BYTES) : PW'(wdata);
        rpos_nx  = rpos_q + PW'(1);
    end

    // Protocol state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= 8'h00;
            status_q <= ST_IDLE;
            key_q    <= '0;
            wpos_q   <= '0;
            rpos_q   <= '0;
            len_q    <= '0;
        end else if (cmd_wr) begin
            cmd_q  <= wdata;
            wpos_q <= '0;
            rpos_q <= '0;
            if (wdata == CMD_READ) begin
                status_q <= ST_ARMED;
            end
        end else if (data_wr && is_read) begin
            if (wpos_q < 3'd4) begin
                case (wpos_q[1:0])
                    2'd0: key_q[31:24] <= wdata;
                    2'd1: key_q[23:16] <= wdata;
                    2'd2: key_q[15:8]  <= wdata;
                    default: key_q[7:0] <= wdata;
                endcase
                status_q <= ST_KEY;
            end else if (wpos_q == 3'd4) begin
                len_q    <= len_cap;
                rpos_q   <= '0;
                status_q <= ST_DATA;
            end
            if (wpos_q != 3'd5) begin
                wpos_q <= wpos_q + 3'd1;
            end
        end else if (data_rd && rd_valid) begin
            rpos_q   <= rpos_nx;
            status_q <= (rpos_nx == len_q) ? ST_IDLE : ST_DATA;
        end
    end
endmodule

// File: rtl/kvq_responder.sv
// Module: top of the keyed record query responder.
// Assumes single-cycle host strobes and that no data read is issued in
// the cycle of the length write (the buffer loads at the end of it).
module kvq_responder #(
    parameter int                                ADDR_W    = 16,
    parameter logic [15:0]                       BASE      = 16'h0300,
    parameter int                                WINDOW    = 32,
    parameter int                                BUF_BYTES = 32,
    parameter logic [kvq_pkg::SECRET_BYTES*8-1:0] SECRET   = kvq_pkg::demo_secret()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam int PW = $clog2(BUF_BYTES + 1);
    localparam int IW = $clog2(BUF_BYTES);

    logic                   data_wr_s, data_rd_s, cmd_wr_s, cmd_rd_s;
    logic [7:0]             cmd_q, status_q;
    logic [31:0]            key_q;
    logic [PW-1:0]          rpos_q, len_q;
    logic                   lookup, rd_valid;
    logic                   tbl_hit;
    logic [7:0]             tbl_len;
    logic [BUF_BYTES*8-1:0] tbl_data;
    logic [7:0]             buf_byte;

    kvq_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .WINDOW(WINDOW)) u_decode (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
        .data_wr(data_wr_s), .data_rd(data_rd_s),
        .cmd_wr(cmd_wr_s), .cmd_rd(cmd_rd_s)
    );

    kvq_ctrl #(.BUF_BYTES(BUF_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr_s), .data_wr(data_wr_s), .data_rd(data_rd_s),
        .wdata(bus_wdata),
        .cmd_q(cmd_q), .status_q(status_q), .key_q(key_q),
        .rpos_q(rpos_q), .len_q(len_q),
        .lookup(lookup), .rd_valid(rd_valid)
    );

    kvq_table #(.BUF_BYTES(BUF_BYTES), .SECRET(SECRET)) u_table (
        .key(key_q), .hit(tbl_hit), .rec_len(tbl_len), .rec_data(tbl_data)
    );

    kvq_buffer #(.BUF_BYTES(BUF_BYTES)) u_buffer (
        .clk(clk), .rst_n(rst_n),
        .load(lookup && tbl_hit), .src_len(tbl_len), .src_data(tbl_data),
        .rd_idx(rpos_q[IW-1:0]), .rd_byte(buf_byte)
    );

    // Read data return
    always_comb begin
        if (cmd_rd_s) begin
            bus_rdata = status_q;
        end else if (data_rd_s && rd_valid) begin
            bus_rdata = buf_byte;
        end else begin
            bus_rdata = 8'h00;
        end
    end
endmodule

// File: rtl/kvq_checker.sv
// Module: protocol checker bound to the responder top.
// Assumes it sees the top's decoded strobes and control state.
module kvq_checker #(
    parameter int BUF_BYTES = 32,
    localparam int PW = $clog2(BUF_BYTES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_wr_s,
    input logic          cmd_rd_s,
    input logic          data_wr_s,
    input logic          data_rd_s,
    input logic [7:0]    bus_wdata,
    input logic [7:0]    bus_rdata,
    input logic [7:0]    status_q,
    input logic [7:0]    cmd_q,
    input logic [PW-1:0] rpos_q,
    input logic [PW-1:0] len_q
);
    AST_READ_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_s && bus_wdata == 8'h10) |=> (status_q == 8'h0C && rpos_q == '0)); // R2

    AST_STATUS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == 8'h00 || status_q == 8'h04 || status_q == 8'h05 || status_q == 8'h0C)); // R7

    AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q <= PW'(BUF_BYTES))); // R4

    AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (rpos_q <= len_q)); // R7

    AST_PAST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd_s && rpos_q == len_q) |-> (bus_rdata == 8'h00)); // R8

    AST_OTHER_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd_s && cmd_q != 8'h10) |=> ($stable(rpos_q) && $stable(status_q))); // R8

    AST_STATUS_READ_PURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd_s && !cmd_wr_s && !data_wr_s && !data_rd_s) |=> $stable(status_q)); // R9

    AST_STATUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd_s |-> (bus_rdata == status_q)); // R9
endmodule

bind kvq_responder kvq_checker #(.BUF_BYTES(BUF_BYTES)) u_kvq_checker (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr_s(cmd_wr_s), .cmd_rd_s(cmd_rd_s),
    .data_wr_s(data_wr_s), .data_rd_s(data_rd_s),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .status_q(status_q), .cmd_q(cmd_q),
    .rpos_q(rpos_q), .len_q(len_q)
);

// File: tb/kvq_responder_bench.sv
// Directed bench for the keyed record query responder.
module kvq_responder_bench;
    localparam logic [15:0] BASE = 16'h0300;
    localparam logic [15:0] A_DATA = BASE;
    localparam logic [15:0] A_CMD  = BASE + 16'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    kvq_responder u_kvq_responder (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] secret_byte(int i);
        return 8'((3 * i + 7) % 256);
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic do_wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_rdwr(logic [15:0] a, logic [7:0] wd, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = wd; bus_wr = 1'b1; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic status_is(string tag, logic [7:0] exp);
        logic [7:0] v;
        do_rd(A_CMD, v);
        chk(tag, v, exp);
    endtask

    task automatic start_query(logic [31:0] key, logic [7:0] len);
        do_wr(A_CMD, 8'h10);
        for (int k = 0; k < 4; k++) begin
            do_wr(A_DATA, key[31-8*k -: 8]);
        end
        do_wr(A_DATA, len);
    endtask

    // R10: reset state, buffer zeroed
    task automatic t_reset();
        logic [7:0] v;
        status_is("R10 status after reset", 8'h00);
        do_rd(A_DATA, v);
        chk("R10 data read after reset", v, 8'h00);
        start_query("ZZZZ", 8'd4);
        for (int i = 0; i < 4; i++) begin
            do_rd(A_DATA, v);
            chk("R10 buffer cleared by reset", v, 8'h00);
        end
    endtask

    // R2 R3 R4 R5 R7 R8: full REV query with phase codes
    task automatic t_rev();
        logic [7:0] v;
        logic [7:0] rev [6] = '{8'h01, 8'h13, 8'h0F, 8'h00, 8'h00, 8'h03};
        do_wr(A_CMD, 8'h10);
        status_is("R2 armed status", 8'h0C);
        do_wr(A_DATA, "R");
        status_is("R3 key entry status", 8'h04);
        do_wr(A_DATA, "E"); do_wr(A_DATA, "V"); do_wr(A_DATA, " ");
        status_is("R3 key entry status after 4", 8'h04);
        do_wr(A_DATA, 8'd6);
        status_is("R4 length accepted status", 8'h05);
        for (int i = 0; i < 6; i++) begin
            do_rd(A_DATA, v);
            chk("R5 REV byte", v, rev[i]);
            status_is("R7 status during stream", (i == 5) ? 8'h00 : 8'h05);
        end
        do_rd(A_DATA, v);
        chk("R8 read past end", v, 8'h00);
        status_is("R8 status unchanged past end", 8'h00);
    endtask

    // R6: partial load keeps tail; miss keeps everything
    task automatic t_partial();
        logic [7:0] v;
        logic [7:0] exp [3] = '{8'h00, 8'h13, 8'h0F};
        start_query("NATJ", 8'd3);
        for (int i = 0; i < 3; i++) begin
            do_rd(A_DATA, v);
            chk("R6 NATJ over REV", v, exp[i]);
        end
        start_query("ABCD", 8'd2);
        for (int i = 0; i < 2; i++) begin
            do_rd(A_DATA, v);
            chk("R6 miss retains buffer", v, exp[i]);
        end
    endtask

    // R4 R5: secret halves, with length capping on OSK1
    task automatic t_secret();
        logic [7:0] v;
        start_query("OSK0", 8'd32);
        for (int i = 0; i < 32; i++) begin
            do_rd(A_DATA, v);
            chk("R5 OSK0 byte", v, secret_byte(i));
        end
        start_query("OSK1", 8'd40);
        for (int i = 0; i < 32; i++) begin
            do_rd(A_DATA, v);
            chk("R5 OSK1 byte", v, secret_byte(32 + i));
        end
        status_is("R4 capped stream done", 8'h00);
        do_rd(A_DATA, v);
        chk("R4 byte beyond cap", v, 8'h00);
    endtask

    // R4: writes after the length change nothing
    task automatic t_extra_writes();
        logic [7:0] v;
        start_query("MSSD", 8'd1);
        do_wr(A_DATA, 8'h55);
        do_wr(A_DATA, 8'hAA);
        status_is("R4 status after extra writes", 8'h05);
        do_rd(A_DATA, v);
        chk("R4 MSSD byte after extra writes", v, 8'h00);
        status_is("R4 stream ends at length 1", 8'h00);
    endtask

    // R2 R8: other commands latch only
    task automatic t_other_cmd();
        logic [7:0] v;
        start_query("REV ", 8'd2);
        do_wr(A_CMD, 8'h11);
        status_is("R2 status kept on non-read cmd", 8'h05);
        do_wr(A_DATA, 8'h77);
        do_rd(A_DATA, v);
        chk("R8 data read under write cmd", v, 8'h00);
        status_is("R8 status after read under write cmd", 8'h05);
        do_wr(A_CMD, 8'h13);
        do_rd(A_DATA, v);
        chk("R8 data read under key-type cmd", v, 8'h00);
    endtask

    // R1: decode of port aliases, unused offsets, outside window
    task automatic t_decode();
        logic [7:0] v;
        do_wr(BASE + 16'd6, 8'h10);
        do_rd(BASE + 16'd5, v);
        chk("R1 command alias offset", v, 8'h0C);
        do_wr(16'h0204, 8'h13);
        status_is("R1 outside window ignored", 8'h0C);
        do_wr(BASE + 16'd12, 8'h11);
        status_is("R1 unused offset write ignored", 8'h0C);
        do_rd(BASE + 16'h10, v);
        chk("R1 unused offset reads zero", v, 8'h00);
        do_wr(BASE + 16'd2, "R"); do_wr(BASE + 16'd3, "E");
        do_wr(BASE + 16'd1, "V"); do_wr(A_DATA, " ");
        do_wr(A_DATA, 8'd1);
        do_rd(BASE + 16'd3, v);
        chk("R1 data alias offset", v, 8'h01);
    endtask

    // R9 R11: same-cycle command write with status read, data rd+wr
    task automatic t_same_cycle();
        logic [7:0] v;
        status_is("R9 status before overlap", 8'h00);
        status_is("R9 repeated status read", 8'h00);
        do_rdwr(A_CMD, 8'h10, v);
        chk("R9 overlap returns old status", v, 8'h00);
        status_is("R9 new status after overlap", 8'h0C);
        do_wr(A_DATA, "R"); do_wr(A_DATA, "E");
        do_wr(A_DATA, "V"); do_wr(A_DATA, " ");
        do_wr(A_DATA, 8'd2);
        do_rdwr(A_DATA, 8'h99, v);
        chk("R11 data rd+wr returns zero", v, 8'h00);
        do_rd(A_DATA, v);
        chk("R11 first byte not consumed", v, 8'h01);
        do_rd(A_DATA, v);
        chk("R11 second byte", v, 8'h13);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rev();
        t_partial();
        t_secret();
        t_extra_writes();
        t_other_cmd();
        t_decode();
        t_same_cycle();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule